// File: doc/BRIEF.md
# SCSI Controller Host Register Interface

This block is the byte-wide register window that a processor uses to drive a legacy SCSI protocol controller. A word-spaced bus address selects one of sixteen slots. Each slot has separate write and read views, so one address can reach different storage depending on direction. The block keeps the readable status, interrupt, sequence-step and configuration registers. It also keeps the written transfer-count bytes, and moves them into the readable counter only when a DMA command is issued.

A byte written to the command slot is split into a DMA flag and a 7-bit opcode. Both go out to the downstream sequencers as a one-clock strobe. Three housekeeping opcodes act locally: flush, chip reset and bus reset. The sequencers report completion through a post input, which loads status, interrupt and step values and raises a level interrupt request. Reading the interrupt slot clears the error bits of the status register and lowers the request. Bus signalling, FIFO storage and command execution are handled by other blocks.

Top module: `scsi_hostif_regs`

## Requirements
- R1: The slot index is bits 5:2 of the bus address. Address bits 1:0 and any bits above bit 5 have no effect on which slot is reached.
- R2: Writes to slot 0 or slot 1 only load the written transfer count and do not change the value read back from those slots. A command byte with bit 7 set copies the written count bytes into the readable slots 0 and 1.
- R3: A write to slot 3 raises `cmd_strobe` for exactly the next clock, with `cmd_opcode` equal to data bits 6:0 and `cmd_dma` equal to data bit 7. Both outputs are zero when there is no strobe. Slot 3 reads back the last command byte.
- R4: Any write to slot 0 or slot 1 clears status bit 4 (terminal count, mask 0x10).
- R5: A read of slot 5 (rd_en high) returns the interrupt value from before the clear. In the same cycle it clears status bits 7, 6 and 5 (mask 0xE0) and drops `irq`.
- R6: Writes to slot 11 store only the bits under mask 0x15. Writes to slots 8 and 12 to 15 store the whole byte. Writes to slots 2, 4, 5, 6, 7, 9 and 10 leave every readable value unchanged.
- R7: After reset every slot reads 0 except slot 14, which reads the revision code (0x04 by default). `irq` and `cmd_strobe` are low.
- R8: Opcode 0x01 (flush) sets slot 5 to 0x08, sets slot 6 to 0 and raises `irq`.
- R9: Opcode 0x02 (chip reset) returns every readable slot and the written counts to their reset values and lowers `irq`.
- R10: Opcode 0x03 (bus reset) sets slot 5 to 0x80. It raises `irq` only when bit 6 of slot 8 is clear; otherwise `irq` is left as it was.
- R11: Any other opcode leaves status, interrupt, step and `irq` unchanged.
- R12: A `post_en` cycle loads slot 4 from `post_status`, slot 5 from `post_intr` and slot 6 from `post_step` (zero-extended), and sets `irq`. `irq` is a level and stays high until a slot-5 read or a reset. Within one cycle a post overrides a read clear and any command except chip reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address from the host bus |
| wr_en | input | 1 | Write strobe for the addressed slot |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, used for the read side effect |
| rd_data | output | 8 | Readable value of the addressed slot (combinational) |
| post_en | input | 1 | Completion report from a sequencer |
| post_status | input | 8 | Status value to load |
| post_intr | input | 8 | Interrupt value to load |
| post_step | input | STEP_W | Sequence step to load |
| irq | output | 1 | Level interrupt request |
| cmd_strobe | output | 1 | One-clock command pulse |
| cmd_opcode | output | 7 | Opcode of the pulsed command |
| cmd_dma | output | 1 | DMA flag of the pulsed command |

## Verification
On every cycle the assertions check these properties:
- the strobe's origin and its DMA qualifier;
- terminal-count clearing;
- the effect of an interrupt-slot read;
- that `irq` holds as a level;
- the masked bus-reset case;
- the result of a chip reset;
- the counter copy on a DMA command.

Only the bench scenarios can show the other behaviours: address aliasing, per-slot write masks, the ignored slots, the pre-clear read value, and the values flush and unknown opcodes leave behind. The bench shows these by comparing every readable slot against a behavioural model, cycle by cycle, under directed and random traffic.

// File: rtl/scsi_hostif_pkg.sv
package scsi_hostif_pkg;
   localparam int SLOT_W    = 4;
   localparam int NUM_SLOTS = 1 << SLOT_W;
   localparam int BYTE_W    = 8;
   localparam int OP_W      = BYTE_W - 1;

   localparam logic [SLOT_W-1:0] SL_CNT_LO = 4'd0;
   localparam logic [SLOT_W-1:0] SL_CNT_HI = 4'd1;
   localparam logic [SLOT_W-1:0] SL_CMD    = 4'd3;
   localparam logic [SLOT_W-1:0] SL_STAT   = 4'd4;
   localparam logic [SLOT_W-1:0] SL_INTR   = 4'd5;
   localparam logic [SLOT_W-1:0] SL_STEP   = 4'd6;

   localparam int CFG_FIRST = 8;
   localparam int CFG_LAST  = 15;
   localparam int NUM_CFG   = CFG_LAST - CFG_FIRST + 1;
   localparam int CFG_REV   = 14;
   localparam int BRST_MASK_BIT = 6;

   localparam logic [OP_W-1:0] OP_FLUSH    = 7'h01;
   localparam logic [OP_W-1:0] OP_CHIP_RST = 7'h02;
   localparam logic [OP_W-1:0] OP_BUS_RST  = 7'h03;

   localparam logic [BYTE_W-1:0] ST_TERM_CNT  = 8'h10;
   localparam logic [BYTE_W-1:0] ST_ERR_CLR   = 8'hE0;
   localparam logic [BYTE_W-1:0] IV_FUNC_DONE = 8'h08;
   localparam logic [BYTE_W-1:0] IV_BUS_RST   = 8'h80;

   // Which bits of a configuration slot accept writes
   function automatic logic [BYTE_W-1:0] cfg_wmask(input int slot);
      case (slot)
         8, 12, 13, 14, 15: return 8'hFF;
         11:                return 8'h15;
         default:           return 8'h00;
      endcase
   endfunction

   function automatic logic [BYTE_W-1:0] cfg_rstval(input int slot, input logic [BYTE_W-1:0] rev);
      return (slot == CFG_REV) ? rev : 8'h00;
   endfunction
endpackage

// File: rtl/scsi_hostif_decode.sv
module scsi_hostif_decode
   import scsi_hostif_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 wr_en_i,
   output logic [SLOT_W-1:0]    slot_o,
   output logic [NUM_SLOTS-1:0] wr_hit_o
);
   localparam int LSB = 2;

   logic unused_addr;
   assign unused_addr = ^addr_i;

   assign slot_o = addr_i[LSB+SLOT_W-1:LSB];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
      assign wr_hit_o[g] = wr_en_i && (slot_o == SLOT_W'(g));
   end
endmodule

// File: rtl/scsi_hostif_cmd.sv
module scsi_hostif_cmd
   import scsi_hostif_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_i,
   input  logic [BYTE_W-1:0] cmd_byte_i,
   output logic              is_flush_o,
   output logic              is_chip_rst_o,
   output logic              is_bus_rst_o,
   output logic              dma_sel_o,
   output logic              strobe_o,
   output logic [OP_W-1:0]   opcode_o,
   output logic              dma_o
);
   logic [OP_W-1:0] op;

   assign op            = cmd_byte_i[OP_W-1:0];
   assign dma_sel_o     = cmd_byte_i[BYTE_W-1];
   assign is_flush_o    = (op == OP_FLUSH);
   assign is_chip_rst_o = (op == OP_CHIP_RST);
   assign is_bus_rst_o  = (op == OP_BUS_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_o <= 1'b0;
         opcode_o <= '0;
         dma_o    <= 1'b0;
      end else if (cmd_wr_i) begin
         strobe_o <= 1'b1;
         opcode_o <= op;
         dma_o    <= dma_sel_o;
      end else begin
         strobe_o <= 1'b0;
         opcode_o <= '0;
         dma_o    <= 1'b0;
      end
   end

   AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> $past(cmd_wr_i)); // R3
   AST_DMA_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      dma_o |-> strobe_o); // R3
endmodule

// File: rtl/scsi_hostif_cfgbank.sv
module scsi_hostif_cfgbank
   import scsi_hostif_pkg::*;
#(
   parameter logic [BYTE_W-1:0] REV_CODE = 8'h04
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           soft_rst_i,
   input  logic [NUM_CFG-1:0]             wr_hit_i,
   input  logic [BYTE_W-1:0]              wdata_i,
   output logic [NUM_CFG-1:0][BYTE_W-1:0] cfg_o
);
   logic [NUM_CFG-1:0] unused_hit;

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
      localparam logic [BYTE_W-1:0] MASK = cfg_wmask(g + CFG_FIRST);
      localparam logic [BYTE_W-1:0] RSTV = cfg_rstval(g + CFG_FIRST, REV_CODE);
      if (MASK == '0) begin : g_fixed
         assign cfg_o[g]      = RSTV;
         assign unused_hit[g] = wr_hit_i[g];
      end else begin : g_store
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           q <= RSTV;
            else if (soft_rst_i)  q <= RSTV;
            else if (wr_hit_i[g]) q <= wdata_i & MASK;
         end
         assign cfg_o[g]      = q;
         assign unused_hit[g] = 1'b0;
      end
   end
endmodule

// File: rtl/scsi_hostif_regs.sv
module scsi_hostif_regs
   import scsi_hostif_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                STEP_W   = 3,
   parameter logic [BYTE_W-1:0] REV_CODE = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              post_en,
   input  logic [BYTE_W-1:0] post_status,
   input  logic [BYTE_W-1:0] post_intr,
   input  logic [STEP_W-1:0] post_step,
   output logic              irq,
   output logic              cmd_strobe,
   output logic [OP_W-1:0]   cmd_opcode,
   output logic              cmd_dma
);
   initial begin : elab_checks
      if (ADDR_W < 6) $fatal(1, "ADDR_W must cover address bit 5");
      if (STEP_W < 1 || STEP_W > BYTE_W) $fatal(1, "STEP_W out of range");
   end

   logic [SLOT_W-1:0]    slot;
   logic [NUM_SLOTS-1:0] wr_hit;
   logic                 cmd_wr, rd_isr;
   logic                 is_flush, is_chip_rst, is_bus_rst, dma_sel;
   logic                 soft_rst;
   logic [NUM_CFG-1:0][BYTE_W-1:0] cfg_q;

   logic [BYTE_W-1:0] cnt_lo_q, cnt_hi_q, wcnt_lo_q, wcnt_hi_q, cmd_q, stat_q, intr_q;
   logic [STEP_W-1:0] step_q;
   logic              irq_q;
   logic [BYTE_W-1:0] cnt_lo_d, cnt_hi_d, wcnt_lo_d, wcnt_hi_d, cmd_d, stat_d, intr_d;
   logic [STEP_W-1:0] step_d;
   logic              irq_d;

   logic unused_hits;
   assign unused_hits = ^{wr_hit[7:4], wr_hit[2]};

   scsi_hostif_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr_i   (bus_addr),
      .wr_en_i  (wr_en),
      .slot_o   (slot),
      .wr_hit_o (wr_hit)
   );

   assign cmd_wr = wr_hit[SL_CMD];
   assign rd_isr = rd_en && (slot == SL_INTR);

   scsi_hostif_cmd u_cmd (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_wr_i      (cmd_wr),
      .cmd_byte_i    (wr_data),
      .is_flush_o    (is_flush),
      .is_chip_rst_o (is_chip_rst),
      .is_bus_rst_o  (is_bus_rst),
      .dma_sel_o     (dma_sel),
      .strobe_o      (cmd_strobe),
      .opcode_o      (cmd_opcode),
      .dma_o         (cmd_dma)
   );

   assign soft_rst = cmd_wr && is_chip_rst;

   scsi_hostif_cfgbank #(.REV_CODE(REV_CODE)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst_i (soft_rst),
      .wr_hit_i   (wr_hit[CFG_LAST:CFG_FIRST]),
      .wdata_i    (wr_data),
      .cfg_o      (cfg_q)
   );

   // Next state: read clear, then writes and commands, then post, chip reset last
   always_comb begin
      cnt_lo_d  = cnt_lo_q;
      cnt_hi_d  = cnt_hi_q;
      wcnt_lo_d = wcnt_lo_q;
      wcnt_hi_d = wcnt_hi_q;
      cmd_d     = cmd_q;
      stat_d    = stat_q;
      intr_d    = intr_q;
      step_d    = step_q;
      irq_d     = irq_q;
      if (rd_isr) begin
         stat_d = stat_d & ~ST_ERR_CLR;
         irq_d  = 1'b0;
      end
      if (wr_hit[SL_CNT_LO]) begin
         wcnt_lo_d = wr_data;
         stat_d    = stat_d & ~ST_TERM_CNT;
      end
      if (wr_hit[SL_CNT_HI]) begin
         wcnt_hi_d = wr_data;
         stat_d    = stat_d & ~ST_TERM_CNT;
      end
      if (cmd_wr) begin
         cmd_d = wr_data;
         if (dma_sel) begin
            cnt_lo_d = wcnt_lo_q;
            cnt_hi_d = wcnt_hi_q;
         end
         if (is_flush) begin
            intr_d = IV_FUNC_DONE;
            step_d = '0;
            irq_d  = 1'b1;
         end
         if (is_bus_rst) begin
            intr_d = IV_BUS_RST;
            if (!cfg_q[0][BRST_MASK_BIT]) irq_d = 1'b1;
         end
      end
      if (post_en) begin
         stat_d = post_status;
         intr_d = post_intr;
         step_d = post_step;
         irq_d  = 1'b1;
      end
      if (soft_rst) begin
         cnt_lo_d  = '0;
         cnt_hi_d  = '0;
         wcnt_lo_d = '0;
         wcnt_hi_d = '0;
         cmd_d     = '0;
         stat_d    = '0;
         intr_d    = '0;
         step_d    = '0;
         irq_d     = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo_q  <= '0;
         cnt_hi_q  <= '0;
         wcnt_lo_q <= '0;
         wcnt_hi_q <= '0;
         cmd_q     <= '0;
         stat_q    <= '0;
         intr_q    <= '0;
         step_q    <= '0;
         irq_q     <= 1'b0;
      end else begin
         cnt_lo_q  <= cnt_lo_d;
         cnt_hi_q  <= cnt_hi_d;
         wcnt_lo_q <= wcnt_lo_d;
         wcnt_hi_q <= wcnt_hi_d;
         cmd_q     <= cmd_d;
         stat_q    <= stat_d;
         intr_q    <= intr_d;
         step_q    <= step_d;
         irq_q     <= irq_d;
      end
   end

   assign irq = irq_q;

   always_comb begin
      rd_data = '0;
      if (slot[SLOT_W-1]) begin
         rd_data = cfg_q[slot[SLOT_W-2:0]];
      end else begin
         case (slot)
            SL_CNT_LO: rd_data = cnt_lo_q;
            SL_CNT_HI: rd_data = cnt_hi_q;
            SL_CMD:    rd_data = cmd_q;
            SL_STAT:   rd_data = stat_q;
            SL_INTR:   rd_data = intr_q;
            SL_STEP:   rd_data = BYTE_W'(step_q);
            default:   rd_data = '0;
         endcase
      end
   end

   AST_ISR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_isr && !post_en && !cmd_wr) |=> (!irq && ((stat_q & ST_ERR_CLR) == '0))); // R5
   AST_TC_CLEAR_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_hit[SL_CNT_LO] || wr_hit[SL_CNT_HI]) && !post_en) |=> !stat_q[4]); // R4
   AST_IRQ_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_isr && !soft_rst) |=> irq); // R12
   AST_BUS_RST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && is_bus_rst && cfg_q[0][BRST_MASK_BIT] && !irq && !post_en) |=> !irq); // R10
   AST_CHIP_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!irq && stat_q == '0 && cfg_q[CFG_REV-CFG_FIRST] == REV_CODE)); // R9
   AST_COUNT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && dma_sel && !is_chip_rst) |=> (cnt_lo_q == $past(wcnt_lo_q) && cnt_hi_q == $past(wcnt_hi_q))); // R2
endmodule

// File: tb/scsi_hostif_regs_tb.sv
module scsi_hostif_regs_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] bus_addr;
   logic       wr_en, rd_en, post_en;
   logic [7:0] wr_data, post_status, post_intr;
   logic [2:0] post_step;
   logic [7:0] rd_data;
   logic       irq, cmd_strobe, cmd_dma;
   logic [6:0] cmd_opcode;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   string cur_tag = "R7";

   always #(CLK_PERIOD/2) clk = ~clk;

   scsi_hostif_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .post_en(post_en), .post_status(post_status),
      .post_intr(post_intr), .post_step(post_step), .irq(irq), .cmd_strobe(cmd_strobe),
      .cmd_opcode(cmd_opcode), .cmd_dma(cmd_dma)
   );

   // Behavioural reference model
   logic [7:0] m_rd [16];
   logic [7:0] m_w0, m_w1;
   logic       m_irq, m_stb, m_dma;
   logic [6:0] m_op;

   task automatic model_clear();
      for (int i = 0; i < 16; i++) m_rd[i] = 8'h00;
      m_rd[14] = 8'h04;
      m_w0 = 0; m_w1 = 0; m_irq = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_clear();
         m_stb = 0; m_op = 0; m_dma = 0;
      end else begin : upd
         int  s;
         bit  crst;
         s    = int'(bus_addr[5:2]);
         crst = 0;
         m_stb = 0; m_op = 0; m_dma = 0;
         if (rd_en && s == 5) begin
            m_rd[4] = m_rd[4] & 8'h1F;
            m_irq   = 0;
         end
         if (wr_en) begin
            if (s == 0) begin m_w0 = wr_data; m_rd[4] = m_rd[4] & 8'hEF; end
            else if (s == 1) begin m_w1 = wr_data; m_rd[4] = m_rd[4] & 8'hEF; end
            else if (s == 3) begin
               m_rd[3] = wr_data;
               m_stb = 1; m_op = wr_data[6:0]; m_dma = wr_data[7];
               if (wr_data[7]) begin m_rd[0] = m_w0; m_rd[1] = m_w1; end
               if (wr_data[6:0] == 7'h01) begin m_rd[5] = 8'h08; m_rd[6] = 0; m_irq = 1; end
               if (wr_data[6:0] == 7'h02) crst = 1;
               if (wr_data[6:0] == 7'h03) begin
                  m_rd[5] = 8'h80;
                  if (!m_rd[8][6]) m_irq = 1;
               end
            end
            else if (s == 8 || s >= 12) m_rd[s] = wr_data;
            else if (s == 11) m_rd[11] = wr_data & 8'h15;
         end
         if (post_en) begin
            m_rd[4] = post_status; m_rd[5] = post_intr; m_rd[6] = {5'b0, post_step}; m_irq = 1;
         end
         if (crst) model_clear();
      end
   end

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Cycle compare against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_tag, "rd_data vs model", rd_data, m_rd[bus_addr[5:2]]);
         chk(cur_tag, "irq vs model", {7'b0, irq}, {7'b0, m_irq});
         chk(cur_tag, "strobe vs model", {7'b0, cmd_strobe}, {7'b0, m_stb});
         chk(cur_tag, "opcode vs model", {1'b0, cmd_opcode}, {1'b0, m_op});
         chk(cur_tag, "dma vs model", {7'b0, cmd_dma}, {7'b0, m_dma});
      end
   end

   task automatic quiet();
      wr_en = 0; rd_en = 0; post_en = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a; wr_data = d; wr_en = 1; rd_en = 0; post_en = 0;
      @(posedge clk); #1;
      quiet();
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(posedge clk); #1;
      bus_addr = a; rd_en = 1; wr_en = 0; post_en = 0;
      #1 v = rd_data;
      @(posedge clk); #1;
      quiet();
   endtask

   task automatic post(input logic [7:0] st, input logic [7:0] iv, input logic [2:0] sp);
      @(posedge clk); #1;
      post_status = st; post_intr = iv; post_step = sp; post_en = 1; wr_en = 0; rd_en = 0;
      @(posedge clk); #1;
      quiet();
   endtask

   task automatic peek(input int slot, input logic [7:0] exp, input string tag);
      bus_addr = 8'(slot << 2);
      #1 chk(tag, $sformatf("slot %0d", slot), rd_data, exp);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: run hung actual=1 expected=0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] v;
      rst_n = 0; bus_addr = 0; wr_data = 0; post_status = 0; post_intr = 0; post_step = 0;
      quiet();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;

      cur_tag = "R7";
      peek(14, 8'h04, "R7"); peek(4, 8'h00, "R7"); peek(5, 8'h00, "R7");
      chk("R7", "irq after reset", {7'b0, irq}, 8'h00);
      chk("R7", "strobe after reset", {7'b0, cmd_strobe}, 8'h00);

      cur_tag = "R1";
      wr(8'hE3, 8'h5A);
      peek(8, 8'h5A, "R1");
      bus_addr = 8'h21; #1 chk("R1", "alias of slot 8", rd_data, 8'h5A);

      cur_tag = "R6";
      wr(8'd44, 8'hFF); peek(11, 8'h15, "R6");
      wr(8'd48, 8'hA5); peek(12, 8'hA5, "R6");
      wr(8'd36, 8'h77); peek(9, 8'h00, "R6");
      wr(8'd16, 8'hFF); peek(4, 8'h00, "R6");
      wr(8'd28, 8'hFF); peek(7, 8'h00, "R6");

      cur_tag = "R12";
      post(8'h9C, 8'h10, 3'd4);
      chk("R12", "irq after post", {7'b0, irq}, 8'h01);
      peek(4, 8'h9C, "R12"); peek(5, 8'h10, "R12"); peek(6, 8'h04, "R12");
      repeat (3) @(posedge clk); #1;
      chk("R12", "irq held as level", {7'b0, irq}, 8'h01);

      cur_tag = "R4";
      wr(8'd0, 8'h34);
      peek(4, 8'h8C, "R4");
      peek(0, 8'h00, "R2");
      wr(8'd4, 8'h12);
      peek(1, 8'h00, "R2");

      cur_tag = "R5";
      rd(8'd20, v);
      chk("R5", "isr read value before clear", v, 8'h10);
      peek(4, 8'h0C, "R5");
      chk("R5", "irq after isr read", {7'b0, irq}, 8'h00);

      cur_tag = "R3";
      wr(8'd12, 8'h80);
      chk("R3", "strobe", {7'b0, cmd_strobe}, 8'h01);
      chk("R3", "opcode", {1'b0, cmd_opcode}, 8'h00);
      chk("R3", "dma flag", {7'b0, cmd_dma}, 8'h01);
      @(posedge clk); #1;
      chk("R3", "strobe one clock only", {7'b0, cmd_strobe}, 8'h00);
      peek(0, 8'h34, "R2"); peek(1, 8'h12, "R2"); peek(3, 8'h80, "R3");

      cur_tag = "R8";
      wr(8'd12, 8'h01);
      chk("R3", "flush opcode", {1'b0, cmd_opcode}, 8'h01);
      chk("R3", "flush dma flag", {7'b0, cmd_dma}, 8'h00);
      peek(5, 8'h08, "R8"); peek(6, 8'h00, "R8");
      chk("R8", "irq after flush", {7'b0, irq}, 8'h01);
      rd(8'd20, v);

      cur_tag = "R10";
      wr(8'd12, 8'h03);
      peek(5, 8'h80, "R10");
      chk("R10", "masked bus reset irq", {7'b0, irq}, 8'h00);
      wr(8'd32, 8'h00);
      wr(8'd12, 8'h03);
      chk("R10", "unmasked bus reset irq", {7'b0, irq}, 8'h01);
      rd(8'd20, v);

      cur_tag = "R11";
      post(8'h04, 8'h20, 3'd2);
      rd(8'd20, v);
      wr(8'd12, 8'h55);
      peek(4, 8'h04, "R11"); peek(5, 8'h20, "R11"); peek(6, 8'h02, "R11");
      chk("R11", "irq after unknown opcode", {7'b0, irq}, 8'h00);

      cur_tag = "R9";
      wr(8'd56, 8'h33);
      peek(14, 8'h33, "R6");
      post(8'hFF, 8'hFF, 3'd7);
      wr(8'd12, 8'h02);
      chk("R9", "irq after chip reset", {7'b0, irq}, 8'h00);
      peek(14, 8'h04, "R9"); peek(8, 8'h00, "R9"); peek(12, 8'h00, "R9");
      peek(11, 8'h00, "R9"); peek(3, 8'h00, "R9"); peek(0, 8'h00, "R9"); peek(4, 8'h00, "R9");

      cur_tag = "R1";
      for (int n = 0; n < 600; n++) begin
         @(posedge clk); #1;
         bus_addr    = 8'($urandom);
         wr_data     = 8'($urandom);
         wr_en       = ($urandom % 3) == 0;
         rd_en       = ($urandom % 3) == 0;
         post_en     = ($urandom % 8) == 0;
         post_status = 8'($urandom);
         post_intr   = 8'($urandom);
         post_step   = 3'($urandom);
      end
      @(posedge clk); #1;
      quiet();
      repeat (2) @(posedge clk);
      #1;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule